// File: doc/BRIEF.md
# Memory Patrol Scrubber

The scrubber walks a protected memory array one word at a time, in ascending address order. For each word it reads the 72-bit codeword, which holds 64 data bits and 8 check bits. If the word has one flipped bit, it writes the repaired codeword back to the same address. If the word cannot be repaired, it leaves the word alone and reports the address on a flag output. A step starts in one of two ways. In manual mode, software sends a one-cycle command. In automatic mode, a programmable gap counter starts the steps, and it is loaded with the sweep period divided by the number of words. The scrubber always yields the memory port while normal traffic is waiting.

The array is treated as rows of `2**COL_W` consecutive words. During a sweep the block counts the repaired words. It also finds the row that needed the most repairs. When the last address has been handled, it raises a one-cycle end-of-sweep strobe and publishes two results. The total repair count is shown only if it is above a minimum. The worst row and its count are shown only if that count is above a second minimum. A result below its minimum reads as zero with its valid flag low. Both accumulators start again from zero at address 0.

Top module: `mem_scrubber`

## Requirements
- R1: Codeword layout. Bit 0 is the even parity over the other 71 bits. Bits at positions 1, 2, 4, 8, 16, 32 and 64 are check bits: the check bit at position 2^k is the XOR of every data position whose index has bit k set. The 64 data bits occupy positions 3..71 that are not powers of two, in ascending order, with data bit 0 at the lowest. A word that decodes clean is read and never written.
- R2: A word with exactly one flipped bit, at any of the 72 positions, is written back at the same address as its original codeword. This happens in the cycle after its read.
- R3: A word with two flipped bits is not written. `ue_flag` pulses for one cycle, the cycle after the read, with `ue_addr` holding that word's address. The word is not counted as a repair.
- R4: With `auto_mode` low, each `step_pulse` cycle causes exactly one read. Reads start at address 0 after reset and go up by one per step, wrapping after the last address.
- R5: With `auto_mode` high, a step starts every `step_gap` cycles, provided a step fits in the gap. `step_pulse` has no effect in this mode.
- R6: `mem_req` is low in every cycle in which `host_busy` is high. A waiting scrub access goes ahead once `host_busy` falls.
- R7: `sweep_end` pulses once after the access to the last address finishes. `sweep_total` is the number of words repaired in that sweep, and `sweep_hit` is high, only when that number exceeds `sweep_min`. Otherwise both are zero.
- R8: `row_worst` and `row_total` name the row (address bits above `COL_W`) with the most repairs in the sweep. On a tie the lowest row wins. They are published with `row_hit` high only when that count exceeds `row_min`; otherwise all three are zero.
- R9: Repair counts never carry over from one sweep into the next sweep's results.
- R10: After reset, no access is pending and all report outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_mode | input | 1 | 1: self-paced steps, 0: manual steps |
| step_pulse | input | 1 | Manual step command, one cycle per step |
| step_gap | input | GAP_W | Cycles between automatic steps |
| sweep_min | input | ADDR_W+1 | Threshold for publishing the sweep repair total |
| row_min | input | ADDR_W+1 | Threshold for publishing the worst row |
| host_busy | input | 1 | Normal access pending; scrubber must yield |
| mem_req | output | 1 | Scrub access request |
| mem_we | output | 1 | 1: write-back, 0: read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 72 | Repaired codeword |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 72 | Codeword read, valid with mem_ack |
| ue_flag | output | 1 | Uncorrectable word seen (one cycle) |
| ue_addr | output | ADDR_W | Address of the uncorrectable word |
| sweep_end | output | 1 | One-cycle end-of-sweep strobe |
| sweep_hit | output | 1 | Sweep total is above threshold |
| sweep_total | output | ADDR_W+1 | Published repair count of the last sweep |
| row_hit | output | 1 | Worst-row count is above threshold |
| row_worst | output | ADDR_W-COL_W | Published worst row |
| row_total | output | COL_W+1 | Published repair count of the worst row |

## Verification
Timing is counted from the cycle a manual command is high. The read comes two cycles later, a write-back comes the cycle after the read, and `ue_flag` appears the cycle after the read. The end-of-sweep strobe and its results come the cycle after the final access of the last word. The bench samples every bus transaction and flag at falling edges. It waits a fixed margin of six cycles after each command before it compares the counts and addresses, so a late or doubled access is seen. In automatic mode, the exact number of cycles between consecutive reads is measured against `step_gap`, both with and without stray manual commands.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
    localparam int CW_W   = 72;
    localparam int DATA_W = 64;
    localparam int SYN_W  = 7;

    typedef logic [CW_W-1:0]   cw_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_FIX
    } scrub_state_e;

    typedef struct packed {
        logic ce;
        logic ue;
        cw_t  fixed;
    } dec_res_t;

    function automatic logic is_pow2(input int p);
        return ((p & (p - 1)) == 0);
    endfunction

    function automatic cw_t secded_encode(input word_t d);
        cw_t cw;
        int  k;
        cw = '0;
        k  = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                cw[p] = d[k];
                k++;
            end
        end
        for (int b = 0; b < SYN_W; b++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < CW_W; p++) begin
                if (!is_pow2(p) && (((p >> b) & 1) == 1)) x = x ^ cw[p];
            end
            cw[1 << b] = x;
        end
        cw[0] = ^cw[CW_W-1:1];
        return cw;
    endfunction

    function automatic word_t secded_extract(input cw_t cw);
        word_t d;
        int    k;
        d = '0;
        k = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                d[k] = cw[p];
                k++;
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/scrub_secded_dec.sv
module scrub_secded_dec
    import scrub_pkg::*;
(
    input  cw_t      cw_in,
    output dec_res_t res
);
    logic [SYN_W-1:0] syn;
    logic             par;
    cw_t              repaired;

    always_comb begin
        syn = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (cw_in[p]) syn = syn ^ SYN_W'(p);
        end
        par      = ^cw_in;
        repaired = cw_in;
        res.ce   = 1'b0;
        res.ue   = 1'b0;
        if (par) begin
            if (int'(syn) < CW_W) begin
                res.ce   = 1'b1;
                repaired = cw_in ^ (cw_t'(1) << syn);
            end else begin
                res.ue = 1'b1;
            end
        end else if (syn != '0) begin
            res.ue = 1'b1;
        end
        res.fixed = secded_encode(secded_extract(repaired));
    end
endmodule

// File: rtl/scrub_pacer.sv
module scrub_pacer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_en,
    input  logic             step_cmd,
    input  logic [GAP_W-1:0] gap,
    output logic             trig
);
    logic [GAP_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!auto_en) begin
            cnt <= '0;
        end else if (cnt == '0) begin
            cnt <= (gap == '0) ? '0 : gap - 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign trig = auto_en ? (cnt == '0) : step_cmd;

    // R5: a reload with a gap above one keeps the next cycle free of a trigger
    p_gap_hold_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && auto_en && $past(auto_en) && $past(trig)
         && gap > GAP_W'(1) && $stable(gap)) |-> !trig);
endmodule

// File: rtl/scrub_stats.sv
module scrub_stats #(
    parameter int ADDR_W = 6,
    parameter int COL_W  = 3,
    parameter int CNT_W  = ADDR_W + 1,
    localparam int ROW_W = ADDR_W - COL_W,
    localparam int RC_W  = COL_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fin,
    input  logic              repaired,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  thr_sweep,
    input  logic [CNT_W-1:0]  thr_row,
    output logic              done,
    output logic              sweep_ok,
    output logic [CNT_W-1:0]  sweep_out,
    output logic              row_ok,
    output logic [ROW_W-1:0]  row_idx_out,
    output logic [RC_W-1:0]   row_cnt_out
);
    logic [CNT_W-1:0] sweep_acc, sweep_nx;
    logic [RC_W-1:0]  row_acc, row_nx, best_acc, best_base, best_nx;
    logic [ROW_W-1:0] best_row, best_row_base, best_row_nx;
    logic             first_word, last_word, first_col, last_col;

    always_comb begin
        first_word    = (addr == '0);
        last_word     = (addr == '1);
        first_col     = (addr[COL_W-1:0] == '0);
        last_col      = (addr[COL_W-1:0] == '1);
        sweep_nx      = (first_word ? '0 : sweep_acc) + CNT_W'(repaired);
        row_nx        = (first_col ? '0 : row_acc) + RC_W'(repaired);
        best_base     = first_word ? '0 : best_acc;
        best_row_base = first_word ? '0 : best_row;
        best_nx       = best_base;
        best_row_nx   = best_row_base;
        if (last_col && row_nx > best_base) begin
            best_nx     = row_nx;
            best_row_nx = addr[ADDR_W-1:COL_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sweep_acc   <= '0;
            row_acc     <= '0;
            best_acc    <= '0;
            best_row    <= '0;
            done        <= 1'b0;
            sweep_ok    <= 1'b0;
            sweep_out   <= '0;
            row_ok      <= 1'b0;
            row_idx_out <= '0;
            row_cnt_out <= '0;
        end else begin
            done <= 1'b0;
            if (fin) begin
                sweep_acc <= sweep_nx;
                row_acc   <= row_nx;
                best_acc  <= best_nx;
                best_row  <= best_row_nx;
                if (last_word) begin
                    done        <= 1'b1;
                    sweep_ok    <= (sweep_nx > thr_sweep);
                    sweep_out   <= (sweep_nx > thr_sweep) ? sweep_nx : '0;
                    row_ok      <= (CNT_W'(best_nx) > thr_row);
                    row_idx_out <= (CNT_W'(best_nx) > thr_row) ? best_row_nx : '0;
                    row_cnt_out <= (CNT_W'(best_nx) > thr_row) ? best_nx : '0;
                end
            end
        end
    end

    // R8: no row can hold more repairs than the whole sweep so far
    p_best_le_sweep_r8: assert property (@(posedge clk) disable iff (rst)
        CNT_W'(best_acc) <= sweep_acc);
    // R7: the end-of-sweep strobe lasts a single cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/mem_scrubber.sv
module mem_scrubber
    import scrub_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int COL_W  = 3,
    parameter int GAP_W  = 16,
    localparam int CNT_W = ADDR_W + 1,
    localparam int ROW_W = ADDR_W - COL_W,
    localparam int RC_W  = COL_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              auto_mode,
    input  logic              step_pulse,
    input  logic [GAP_W-1:0]  step_gap,
    input  logic [CNT_W-1:0]  sweep_min,
    input  logic [CNT_W-1:0]  row_min,
    input  logic              host_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [71:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [71:0]       mem_rdata,
    output logic              ue_flag,
    output logic [ADDR_W-1:0] ue_addr,
    output logic              sweep_end,
    output logic              sweep_hit,
    output logic [CNT_W-1:0]  sweep_total,
    output logic              row_hit,
    output logic [ROW_W-1:0]  row_worst,
    output logic [RC_W-1:0]   row_total
);
    scrub_state_e      state;
    logic [ADDR_W-1:0] ptr;
    logic              pend, trig, xfer, fin;
    cw_t               fix_q;
    dec_res_t          dec;

    scrub_pacer #(.GAP_W(GAP_W)) u_pacer (
        .clk      (clk),
        .rst      (rst),
        .auto_en  (auto_mode),
        .step_cmd (step_pulse),
        .gap      (step_gap),
        .trig     (trig)
    );

    scrub_secded_dec u_dec (
        .cw_in (mem_rdata),
        .res   (dec)
    );

    assign mem_req   = (state != ST_IDLE) && !host_busy;
    assign mem_we    = (state == ST_FIX);
    assign mem_addr  = ptr;
    assign mem_wdata = fix_q;
    assign xfer      = mem_req && mem_ack;
    assign fin       = xfer && ((state == ST_FIX) || !dec.ce);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ptr     <= '0;
            pend    <= 1'b0;
            fix_q   <= '0;
            ue_flag <= 1'b0;
            ue_addr <= '0;
        end else begin
            pend    <= trig || (pend && state != ST_IDLE);
            ue_flag <= 1'b0;
            case (state)
                ST_IDLE: if (pend) state <= ST_READ;
                ST_READ: if (xfer) begin
                    if (dec.ce) begin
                        fix_q <= dec.fixed;
                        state <= ST_FIX;
                    end else begin
                        state   <= ST_IDLE;
                        ue_flag <= dec.ue;
                        if (dec.ue) ue_addr <= ptr;
                    end
                end
                ST_FIX:  if (xfer) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
            if (fin) ptr <= ptr + 1'b1;
        end
    end

    scrub_stats #(.ADDR_W(ADDR_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_stats (
        .clk         (clk),
        .rst         (rst),
        .fin         (fin),
        .repaired    (state == ST_FIX),
        .addr        (ptr),
        .thr_sweep   (sweep_min),
        .thr_row     (row_min),
        .done        (sweep_end),
        .sweep_ok    (sweep_hit),
        .sweep_out   (sweep_total),
        .row_ok      (row_hit),
        .row_idx_out (row_worst),
        .row_cnt_out (row_total)
    );

    // R3: the decoder never calls a word both repairable and lost
    p_flags_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(dec.ce && dec.ue));
    // R2: a write-back targets the word that was just read
    p_fix_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIX) |-> $stable(ptr));
    // R3: an uncorrectable report lasts one cycle
    p_ue_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        ue_flag |=> !ue_flag);
    // R7: the sweep ends exactly when the pointer wraps to zero
    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        sweep_end |-> (ptr == '0));
endmodule

// File: tb/mem_scrubber_tb.sv
`timescale 1ns/1ps
module mem_scrubber_tb;
    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic        clk = 1'b0;
    logic        rst;
    logic        auto_mode, step_pulse, host_busy;
    logic [15:0] step_gap;
    logic [6:0]  sweep_min, row_min;
    logic        mem_req, mem_we, mem_ack;
    logic [5:0]  mem_addr, ue_addr;
    logic [71:0] mem_wdata, mem_rdata;
    logic        ue_flag, sweep_end, sweep_hit, row_hit;
    logic [6:0]  sweep_total;
    logic [2:0]  row_worst;
    logic [3:0]  row_total;

    logic [71:0] mem  [NW];
    logic [71:0] gold [NW];
    int          kind [NW];

    int checks = 0, fails = 0, cyc = 0;
    int rd_cnt = 0, wr_cnt = 0, ue_cnt = 0, done_cnt = 0, yield_bad = 0;
    int last_rd_addr, last_wr_addr, last_ue_addr;
    logic [71:0] last_wr_data;
    int cap_hit, cap_total, cap_rhit, cap_row, cap_rtot;
    bit gap_chk = 0, have_prev = 0;
    int prev_rd = 0, gap_seen = 0, gap_bad = 0;

    always #2.5 clk = ~clk;

    mem_scrubber u_dut (
        .clk(clk), .rst(rst), .auto_mode(auto_mode), .step_pulse(step_pulse),
        .step_gap(step_gap), .sweep_min(sweep_min), .row_min(row_min),
        .host_busy(host_busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .ue_flag(ue_flag), .ue_addr(ue_addr),
        .sweep_end(sweep_end), .sweep_hit(sweep_hit), .sweep_total(sweep_total),
        .row_hit(row_hit), .row_worst(row_worst), .row_total(row_total)
    );

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_req && mem_we && mem_ack) mem[mem_addr] <= mem_wdata;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                wr_cnt++; last_wr_addr = int'(mem_addr); last_wr_data = mem_wdata;
            end else begin
                rd_cnt++; last_rd_addr = int'(mem_addr);
                if (gap_chk) begin
                    if (have_prev) begin
                        gap_seen++;
                        if (cyc - prev_rd != int'(step_gap)) gap_bad++;
                    end
                    have_prev = 1; prev_rd = cyc;
                end
            end
        end
        if (!gap_chk) have_prev = 0;
        if (host_busy && mem_req) yield_bad++;
        if (ue_flag) begin ue_cnt++; last_ue_addr = int'(ue_addr); end
        if (sweep_end) begin
            done_cnt++;
            cap_hit = int'(sweep_hit); cap_total = int'(sweep_total);
            cap_rhit = int'(row_hit); cap_row = int'(row_worst); cap_rtot = int'(row_total);
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    function automatic logic [71:0] benc(input logic [63:0] d);
        logic [71:0] w;
        logic [6:0]  s;
        int          j;
        w = '0; j = 0;
        for (int p = 3; p < 72; p++) if ((p & (p - 1)) != 0) begin w[p] = d[j]; j++; end
        s = '0;
        for (int p = 3; p < 72; p++) if (w[p]) s = s ^ 7'(p);
        for (int b = 0; b < 7; b++) w[1 << b] = s[b];
        w[0] = ^w[71:1];
        return w;
    endfunction

    task automatic restore_all();
        for (int a = 0; a < NW; a++) begin mem[a] = gold[a]; kind[a] = 0; end
    endtask

    task automatic put_single(input int a, input int p);
        mem[a] = gold[a] ^ (72'(1) << p); kind[a] = 1;
    endtask

    task automatic do_step(input int a, input bit yld);
        int rd0, wr0, ue0;
        rd0 = rd_cnt; wr0 = wr_cnt; ue0 = ue_cnt;
        step_pulse = 1'b1;
        if (yld) host_busy = 1'b1;
        tick();
        step_pulse = 1'b0;
        if (yld) begin
            repeat (4) tick();
            chk("R6 no read while host busy", rd_cnt - rd0, 0);
            host_busy = 1'b0;
        end
        repeat (6) tick();
        chk("R4 one read per command", rd_cnt - rd0, 1);
        chk("R4 ascending address", last_rd_addr, a);
        if (kind[a] == 1) begin
            chk("R2 one write-back", wr_cnt - wr0, 1);
            chk("R2 write address", last_wr_addr, a);
            chk("R2 repaired codeword", last_wr_data, gold[a]);
            chk("R3 no flag on single error", ue_cnt - ue0, 0);
        end else if (kind[a] == 2) begin
            chk("R3 no write on double error", wr_cnt - wr0, 0);
            chk("R3 flag pulse", ue_cnt - ue0, 1);
            chk("R3 flag address", last_ue_addr, a);
        end else begin
            chk("R1 clean word not written", wr_cnt - wr0, 0);
            chk("R1 clean word not flagged", ue_cnt - ue0, 0);
        end
    endtask

    task automatic expect_report(input int ms, input int mr, input string tg);
        int tot, best, brow;
        int rc [8];
        tot = 0; best = 0; brow = 0;
        for (int r = 0; r < 8; r++) rc[r] = 0;
        for (int a = 0; a < NW; a++) if (kind[a] == 1) begin tot++; rc[a >> 3]++; end
        for (int r = 0; r < 8; r++) if (rc[r] > best) begin best = rc[r]; brow = r; end
        chk({"R7 sweep hit ", tg}, cap_hit, (tot > ms) ? 1 : 0);
        chk({"R7 sweep total ", tg}, cap_total, (tot > ms) ? tot : 0);
        chk({"R8 row hit ", tg}, cap_rhit, (best > mr) ? 1 : 0);
        chk({"R8 worst row ", tg}, cap_row, (best > mr) ? brow : 0);
        chk({"R8 worst row count ", tg}, cap_rtot, (best > mr) ? best : 0);
    endtask

    initial begin
        int d0;
        void'($urandom(32'd20241));
        rst = 1'b1; auto_mode = 0; step_pulse = 0; host_busy = 0;
        step_gap = 16'd4; sweep_min = 7'd2; row_min = 7'd1;
        for (int a = 0; a < NW; a++) gold[a] = benc({$urandom, $urandom});
        restore_all();
        for (int a = 3; a < NW; a++) begin
            int r, p;
            r = $urandom % 8; p = $urandom % 72;
            if (r == 5 || r == 6) put_single(a, p);
            else if (r == 7) begin
                mem[a] = gold[a] ^ (72'(1) << p) ^ (72'(1) << ((p + 1 + $urandom % 71) % 72));
                kind[a] = 2;
            end
        end
        put_single(0, 0);
        put_single(1, 64);
        mem[2] = gold[2] ^ (72'(1) << 5) ^ (72'(1) << 70); kind[2] = 2;
        repeat (4) tick();
        rst = 1'b0;
        tick();
        chk("R10 no request after reset", mem_req, 0);
        chk("R10 no flag after reset", ue_flag, 0);
        chk("R10 no sweep strobe after reset", sweep_end, 0);
        chk("R10 reports low after reset", {sweep_hit, row_hit, sweep_total, row_total}, 0);

        // first sweep, manual, random error mix
        for (int a = 0; a < NW; a++) do_step(a, (a % 9) == 4);
        chk("R7 one sweep strobe", done_cnt, 1);
        expect_report(2, 1, "sweep1");
        for (int a = 0; a < NW; a++)
            if (kind[a] == 1) chk("R2 memory repaired", mem[a], gold[a]);

        // second sweep: tie between rows, total suppressed
        restore_all();
        put_single(24, 10); put_single(29, 0); put_single(48, 71); put_single(55, 32);
        sweep_min = 7'd4; row_min = 7'd1;
        for (int a = 0; a < NW; a++) do_step(a, (a % 13) == 6);
        chk("R7 second strobe", done_cnt, 2);
        expect_report(4, 1, "sweep2 R9");

        // third sweep: automatic mode, one repair, row suppressed
        restore_all();
        put_single(42, 17);
        sweep_min = 7'd0; row_min = 7'd2; step_gap = 16'd4;
        d0 = done_cnt;
        gap_chk = 1; auto_mode = 1'b1;
        repeat (NW * 4 + 2) tick();
        auto_mode = 1'b0; gap_chk = 0;
        repeat (6) tick();
        chk("R5 automatic sweep finished once", done_cnt - d0, 1);
        chk("R5 automatic spacing", gap_bad, 0);
        chk("R2 automatic repair in memory", mem[42], gold[42]);
        expect_report(0, 2, "sweep3 R9");

        // automatic mode with a longer gap while manual commands are spammed
        step_gap = 16'd37; gap_seen = 0; gap_bad = 0;
        gap_chk = 1; auto_mode = 1'b1; step_pulse = 1'b1;
        repeat (37 * 6) tick();
        auto_mode = 1'b0; step_pulse = 1'b0; gap_chk = 0;
        repeat (6) tick();
        chk("R5 reads observed in long gap", gap_seen >= 4, 1);
        chk("R5 manual command ignored in auto", gap_bad, 0);
        chk("R6 never requested while host busy", yield_bad, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule